// File: doc/BRIEF.md
# Masked configuration register space

This block holds the 256-byte configuration space of a bus device as byte-wide registers. A requester reads or writes 1, 2 or 4 bytes starting at any byte address. Every byte has its own write mask, fixed at elaboration, and a write changes only the masked bits. The remaining bits keep their reset value, which makes identification fields, type bits and window size bits read-only.

The write masks come from parameters. These give the power-of-two size of each of six base-address windows, the size of the expansion-ROM window, and whether a window decodes I/O space. Values are little-endian: the byte at the addressed location appears in data bits 7:0.

A one-cycle remap pulse tells the decode logic next to the block to rebuild its windows. It fires after a write that alters a base-address register or flips the memory-space or I/O-space enable bit.

Top module: `cfg_space`

## Requirements
- R1: A written byte at location a takes the value (old & ~M[a]) | (new & M[a]), where M[a] is that byte's write mask; bits outside M[a] never change.
- R2: Base-address register n (n = 0..5) occupies bytes 0x10+4n..0x13+4n. For a window of 2^k bytes its 32-bit write mask is ~(2^k − 1). k = 0 means the window is absent and the whole register is read-only. After reset bit 0 of an implemented I/O window reads 1 and all other bits read 0.
- R3: The expansion-ROM register at bytes 0x30..0x33 has write mask ~(2^k − 1) | 1 for a ROM of 2^k bytes, so bit 0 (the ROM enable) is writable. k = 0 makes the register read-only.
- R4: In the command register at bytes 0x04..0x05 only bit 0 (I/O-space enable), bit 1 (memory-space enable) and bit 2 (bus master) are writable. Byte 0x05 is read-only.
- R5: Bytes 0x0C and 0x3C are fully writable, as is every byte from 0x40 upward. Every other byte below 0x40 not named in R2–R4 is read-only. Bytes 0x00–0x01 hold the vendor ID and bytes 0x02–0x03 the device ID from parameters.
- R6: size_i encodes the width as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A 4-byte read runs only at addresses up to 0xFC and otherwise becomes a 2-byte read. A 2-byte read runs only at addresses up to 0xFE and otherwise becomes a 1-byte read. Unread lanes of rdata_o are zero.
- R7: Data is little-endian: byte a+i maps to data bits 8i+7..8i on reads and writes.
- R8: Lanes of a write that would land beyond byte 0xFF are dropped. The write does not wrap to byte 0x00.
- R9: remap_o is high for the one cycle after a write that changes any byte in 0x10..0x27, or changes command bit 0 or bit 1. Otherwise it is low. ROM or bus-master changes do not raise it.
- R10: rdata_o is registered. It updates on the clock edge that samples rd_en_i and holds otherwise. A read and write in the same cycle return the contents from before the write.
- R11: During and after reset rdata_o and remap_o are 0. All bytes are 0 except the IDs of R5 and the I/O bits of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request this cycle |
| rd_en_i | input | 1 | Read request this cycle |
| addr_i | input | 8 | Starting byte address |
| size_i | input | 2 | Access width code (R6) |
| wdata_i | input | 32 | Write data, little-endian |
| rdata_o | output | 32 | Registered read data |
| remap_o | output | 1 | Window remap pulse |

## Verification
The assertions assume that wr_en_i, rd_en_i, addr_i and size_i carry known values at every sampled edge after reset. They also assume that a size code of 3 is a legal alias for 4 bytes and not a fault. The stimulus changes inputs only on the falling edge and returns both enables to zero after each operation. It mixes directed accesses at the header edges, at 0xFC–0xFF and at simultaneous read-write with a long pseudo-random run biased toward the header. The random run uses every size code, including 3.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int unsigned CFG_BYTES = 256;
  localparam int unsigned NUM_BARS  = 6;
  localparam int unsigned SZW       = 5;
  localparam int unsigned BAR_BASE  = 16;
  localparam int unsigned BAR_BYTES = 4 * NUM_BARS;
  localparam int unsigned ROM_BASE  = 48;
  localparam int unsigned CMD_ADDR  = 4;
  localparam int unsigned CLS_ADDR  = 12;
  localparam int unsigned ILN_ADDR  = 60;
  localparam int unsigned HDR_END   = 64;

  function automatic logic [31:0] win_mask(int unsigned k);
    if (k == 0) return 32'h0;
    return ~((32'h1 << k) - 32'h1);
  endfunction

  function automatic logic [7:0] byte_wmask(int unsigned a,
                                            logic [NUM_BARS*SZW-1:0] bsz,
                                            int unsigned rsz);
    logic [31:0] m;
    int unsigned n;
    if (a >= HDR_END) return 8'hFF;
    if (a == CLS_ADDR || a == ILN_ADDR) return 8'hFF;
    if (a == CMD_ADDR) return 8'h07;
    if (a >= BAR_BASE && a < BAR_BASE + BAR_BYTES) begin
      n = (a - BAR_BASE) / 4;
      m = win_mask(int'(bsz[n*SZW +: SZW]));
      return m[8*(a%4) +: 8];
    end
    if (a >= ROM_BASE && a < ROM_BASE + 4) begin
      m = (rsz == 0) ? 32'h0 : (win_mask(rsz) | 32'h1);
      return m[8*(a%4) +: 8];
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] byte_reset(int unsigned a,
                                            logic [15:0] ven,
                                            logic [15:0] dev,
                                            logic [NUM_BARS*SZW-1:0] bsz,
                                            logic [NUM_BARS-1:0] bio);
    int unsigned n;
    case (a)
      0: return ven[7:0];
      1: return ven[15:8];
      2: return dev[7:0];
      3: return dev[15:8];
      default: ;
    endcase
    if (a >= BAR_BASE && a < BAR_BASE + BAR_BYTES && (a % 4) == 0) begin
      n = (a - BAR_BASE) / 4;
      return (bsz[n*SZW +: SZW] != '0 && bio[n]) ? 8'h01 : 8'h00;
    end
    return 8'h00;
  endfunction
endpackage

// File: rtl/cfg_wr_lane.sv
module cfg_wr_lane #(
  parameter int unsigned ADDR  = 0,
  parameter logic [7:0]  WMASK = 8'h00,
  parameter logic [7:0]  RSTV  = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  addr_i,
  input  logic [2:0]  nbytes_i,
  input  logic [31:0] wdata_i,
  output logic [7:0]  q_o,
  output logic [7:0]  nxt_o
);
  logic [8:0] off;
  logic       hit;
  logic [7:0] wbyte;

  // negative offset means the write starts above this byte; no wrap past 0xFF
  assign off   = 9'(ADDR) - {1'b0, addr_i};
  assign hit   = wr_en_i & ~off[8] & (off[7:0] < {5'd0, nbytes_i});
  assign wbyte = wdata_i[8*off[1:0] +: 8];
  assign nxt_o = hit ? ((q_o & ~WMASK) | (wbyte & WMASK)) : q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RSTV;
    else         q_o <= nxt_o;
  end

  assert_ro_bits_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & ~WMASK) == ($past(q_o) & ~WMASK)));

  assert_untouched_lane_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q_o));
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_space_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_en_i,
  input  logic [7:0]                addr_i,
  input  logic [1:0]                size_i,
  input  logic [CFG_BYTES-1:0][7:0] mem_i,
  output logic [31:0]               rdata_o
);
  logic       w4, w2;
  logic [3:0] lane_en;
  logic [31:0] rdata_d;

  assign w4 = (size_i[1]) && (addr_i <= 8'hFC);
  assign w2 = !w4 && (size_i != 2'd0) && (addr_i <= 8'hFE);
  assign lane_en = {w4, w4, w4 | w2, 1'b1};

  for (genvar k = 0; k < 4; k++) begin : g_rd_lane
    logic [7:0] idx;
    assign idx = addr_i + 8'(k);
    assign rdata_d[8*k +: 8] = lane_en[k] ? mem_i[idx] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rdata_d;
  end

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  assert_top_byte_narrow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 8'hFF) |=> (rdata_o[31:8] == 24'h0));

  assert_single_byte_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && size_i == 2'd0) |=> (rdata_o[31:8] == 24'h0));
endmodule

// File: rtl/cfg_remap_det.sv
module cfg_remap_det
  import cfg_space_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [BAR_BYTES-1:0][7:0] bar_cur_i,
  input  logic [BAR_BYTES-1:0][7:0] bar_nxt_i,
  input  logic [1:0]                dec_cur_i,
  input  logic [1:0]                dec_nxt_i,
  output logic                      remap_o
);
  logic changed;

  assign changed = (bar_cur_i != bar_nxt_i) || (dec_cur_i != dec_nxt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) remap_o <= 1'b0;
    else         remap_o <= wr_en_i & changed;
  end

  assert_remap_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o |-> $past(wr_en_i));

  assert_remap_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !remap_o);
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_space_pkg::*;
#(
  parameter logic [15:0]            VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0]            DEVICE_ID   = 16'h0042,
  parameter logic [NUM_BARS*SZW-1:0] BAR_SZ_LOG2 = {5'd0, 5'd0, 5'd0, 5'd0, 5'd5, 5'd12},
  parameter logic [NUM_BARS-1:0]    BAR_IS_IO   = 6'b000010,
  parameter int unsigned            ROM_SZ_LOG2 = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [7:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        remap_o
);
  logic [CFG_BYTES-1:0][7:0] mem_q;
  logic [CFG_BYTES-1:0][7:0] mem_nxt;
  logic [2:0]                nbytes;

  assign nbytes = (size_i == 2'd0) ? 3'd1 : (size_i == 2'd1) ? 3'd2 : 3'd4;

  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_lane
    localparam logic [7:0] WM = byte_wmask(g, BAR_SZ_LOG2, ROM_SZ_LOG2);
    localparam logic [7:0] RV = byte_reset(g, VENDOR_ID, DEVICE_ID, BAR_SZ_LOG2, BAR_IS_IO);
    cfg_wr_lane #(.ADDR(g), .WMASK(WM), .RSTV(RV)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .nbytes_i(nbytes),
      .wdata_i (wdata_i),
      .q_o     (mem_q[g]),
      .nxt_o   (mem_nxt[g])
    );
  end

  cfg_rd_mux u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en_i),
    .addr_i (addr_i),
    .size_i (size_i),
    .mem_i  (mem_q),
    .rdata_o(rdata_o)
  );

  cfg_remap_det u_remap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .bar_cur_i(mem_q[BAR_BASE +: BAR_BYTES]),
    .bar_nxt_i(mem_nxt[BAR_BASE +: BAR_BYTES]),
    .dec_cur_i(mem_q[CMD_ADDR][1:0]),
    .dec_nxt_i(mem_nxt[CMD_ADDR][1:0]),
    .remap_o  (remap_o)
  );

  assert_cmd_high_ro_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(mem_q[CMD_ADDR+1]));
endmodule

// File: tb/sim_cfg_space.sv
module sim_cfg_space;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        remap;

  int tests = 0;
  int fails = 0;

  localparam logic [15:0] VEN = 16'hC0DE;
  localparam logic [15:0] DEV = 16'h0042;
  int bsz [6] = '{12, 5, 0, 0, 0, 0};
  bit bio [6] = '{0, 1, 0, 0, 0, 0};
  int rom_sz = 16;

  logic [7:0]  m [256];
  logic [31:0] exp_rd = '0;
  logic        exp_rm = 1'b0;

  always #10 clk = ~clk;

  cfg_space #(
    .VENDOR_ID(VEN), .DEVICE_ID(DEV),
    .BAR_SZ_LOG2({5'd0, 5'd0, 5'd0, 5'd0, 5'd5, 5'd12}),
    .BAR_IS_IO(6'b000010), .ROM_SZ_LOG2(16)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .size_i(size), .wdata_i(wdata),
    .rdata_o(rdata), .remap_o(remap)
  );

  function automatic logic [7:0] bmask(int a);
    logic [31:0] w;
    int k;
    if (a >= 64 || a == 12 || a == 60) return 8'hFF;
    if (a == 4) return 8'h07;
    if (a >= 16 && a < 40) begin
      k = bsz[(a - 16) / 4];
      w = (k == 0) ? 32'h0 : ~((32'h1 << k) - 32'h1);
      return w[8*(a%4) +: 8];
    end
    if (a >= 48 && a < 52) begin
      w = (rom_sz == 0) ? 32'h0 : (~((32'h1 << rom_sz) - 32'h1) | 32'h1);
      return w[8*(a%4) +: 8];
    end
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    m[0] = VEN[7:0]; m[1] = VEN[15:8]; m[2] = DEV[7:0]; m[3] = DEV[15:8];
    for (int n = 0; n < 6; n++) if (bsz[n] != 0 && bio[n]) m[16 + 4*n] = 8'h01;
  endtask

  function automatic logic [31:0] mread(int a, int sz);
    int w;
    logic [31:0] r = '0;
    w = (sz >= 2 && a <= 252) ? 4 : (sz >= 1 && a <= 254) ? 2 : 1;
    for (int k = 0; k < w; k++) r[8*k +: 8] = m[a + k];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(string tag, bit w, bit r, int a, int sz, logic [31:0] d);
    int nb;
    bit ch = 0;
    logic [7:0] nv;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 8'(a); size = 2'(sz); wdata = d;
    if (r) exp_rd = mread(a, sz);
    if (w) begin
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      for (int k = 0; k < nb; k++) begin
        if (a + k <= 255) begin
          nv = (m[a+k] & ~bmask(a+k)) | (d[8*k +: 8] & bmask(a+k));
          if (a + k >= 16 && a + k < 40 && nv != m[a+k]) ch = 1;
          if (a + k == 4 && ((nv ^ m[4]) & 8'h03) != 0) ch = 1;
          m[a+k] = nv;
        end
      end
    end
    exp_rm = w && ch;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rdata"}, rdata, exp_rd);
    chk({tag, " remap"}, {31'd0, remap}, {31'd0, exp_rm});
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R11 rdata in reset", rdata, 32'h0);
    chk("R11 remap in reset", {31'd0, remap}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rdata after reset", rdata, 32'h0);

    op("R11", 0, 1, 0, 2, 0);
    chk("R5 ids", rdata, {DEV, VEN});
    op("R7", 0, 1, 2, 0, 0);
    chk("R7 byte lane", rdata, 32'h0000_0042);
    op("R2", 0, 1, 20, 2, 0);
    chk("R2 io reset bit", rdata, 32'h0000_0001);
    op("R2", 1, 0, 16, 2, 32'hFFFF_FFFF);
    op("R2", 0, 1, 16, 2, 0);
    chk("R2 bar0 mask", rdata, 32'hFFFF_F000);
    op("R9", 1, 0, 16, 2, 32'hFFFF_FFFF);
    op("R2", 1, 0, 20, 3, 32'hFFFF_FFFF);
    op("R2", 0, 1, 20, 2, 0);
    chk("R2 bar1 io mask", rdata, 32'hFFFF_FFE1);
    op("R2", 1, 0, 24, 2, 32'hFFFF_FFFF);
    op("R2", 0, 1, 24, 2, 0);
    chk("R2 absent bar", rdata, 32'h0);
    op("R3", 1, 0, 48, 2, 32'hFFFF_FFFF);
    op("R3", 0, 1, 48, 2, 0);
    chk("R3 rom mask", rdata, 32'hFFFF_0001);
    op("R4", 1, 0, 4, 1, 32'h0000_FFFF);
    op("R4", 0, 1, 4, 1, 0);
    chk("R4 command", rdata, 32'h0000_0007);
    op("R9", 1, 0, 4, 0, 32'h0000_0004);
    op("R9", 1, 0, 4, 0, 32'h0000_0000);
    op("R5", 1, 0, 12, 0, 32'h0000_00A5);
    op("R5", 1, 0, 60, 0, 32'h0000_005A);
    op("R5", 1, 0, 8, 2, 32'hFFFF_FFFF);
    op("R5", 1, 0, 64, 2, 32'h1234_5678);
    op("R5", 0, 1, 8, 2, 0);
    chk("R5 class ro", rdata, 32'h0);
    op("R8", 1, 0, 254, 2, 32'hAABB_CCDD);
    op("R8", 0, 1, 252, 2, 0);
    op("R8", 0, 1, 0, 2, 0);
    chk("R8 no wrap", rdata, {DEV, VEN});
    op("R6", 0, 1, 253, 2, 0);
    op("R6", 0, 1, 255, 1, 0);
    op("R6", 0, 1, 255, 3, 0);
    op("R6", 0, 1, 254, 3, 0);
    op("R10", 1, 1, 64, 2, 32'hCAFE_F00D);
    chk("R10 old data", rdata, 32'h1234_5678);
    op("R10", 0, 0, 64, 2, 0);
    op("R10", 0, 1, 64, 2, 0);
    chk("R10 new data", rdata, 32'hCAFE_F00D);

    for (int i = 0; i < 4000; i++) begin
      int a;
      a = ($urandom % 2 == 0) ? int'($urandom % 68) : int'($urandom % 256);
      op("R1", $urandom % 3 != 0, $urandom % 2 == 0, a, $urandom % 4, $urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule